// File: doc/BRIEF.md
# Banked Internal Data RAM Controller

This block is the 256-byte on-chip scratchpad of an 8-bit microcontroller core. It receives already decoded accesses and turns each into a byte location, or into a request to the special-function-register space. Four addressing kinds are resolved. Direct byte accesses reach RAM only in the lower half; direct addresses with the top bit set are passed to the register space. Indirect byte accesses reach every RAM byte. Bit accesses use a 7-bit bit address into a sixteen-byte bit window. Register accesses name one of eight working registers in the bank picked by a 2-bit bank select.

The block also holds the stack pointer. A push increments the pointer and then stores. A pop shows the byte at the pointer and then decrements it. The read and write ports, the push and pop strobes and the register-space request are plain single-cycle strobes. Every access is taken in the cycle it is presented, so there is no back-pressure and no ready signal. Reads are combinational and return the contents from before any write made on the same clock edge.

Top module: `iram_ctrl`

## Requirements
- R1: After reset `sp` is 07h and every RAM byte reads 00h.
- R2: Mode code 00 (direct) with address 00h–7Fh uses RAM. With address 80h–FFh it raises `sfr_rd_en` or `sfr_wr_en` and passes the address and write data through. `rd_data` then equals `sfr_rdata`, and RAM is not changed.
- R3: Mode code 01 (indirect) reaches all 256 RAM bytes and never raises an SFR strobe.
- R4: Mode code 11 (register) addresses byte `bank_sel*8 + addr[2:0]`; `addr[7:3]` is ignored.
- R5: Mode code 10 (bit) addresses bit `addr[2:0]` of byte `20h + addr[6:3]`. `addr[7]` is ignored. A read returns the bit in `rd_data[0]`, with bits 7:1 at zero.
- R6: A bit write stores `wr_data[0]` into the one bit and leaves the other seven bits of the byte unchanged.
- R7: A push alone increments `sp` and then writes `push_data` at the new `sp`, so the first push after reset lands at 08h. `pop_data` always shows the byte at `sp`.
- R8: A pop alone decrements `sp` after `pop_data` has shown the top byte. `sp` wraps modulo 256.
- R9: Push and pop in the same cycle leave `sp` and RAM unchanged.
- R10: A read and a write to the same byte in one cycle return the old value; the new value is readable in the next cycle.
- R11: If the write port and a push hit the same byte in one cycle, the pushed byte is kept.
- R12: With `rd_en` low, `rd_data` is 00h and `sfr_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel | input | 2 | Active register bank |
| rd_en | input | 1 | Read strobe |
| rd_mode | input | 2 | Read addressing mode (00 direct, 01 indirect, 10 bit, 11 register) |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read result, combinational |
| wr_en | input | 1 | Write strobe |
| wr_mode | input | 2 | Write addressing mode, same codes as `rd_mode` |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data; bit mode uses bit 0 |
| push | input | 1 | Stack push strobe |
| push_data | input | 8 | Byte to push |
| pop | input | 1 | Stack pop strobe |
| pop_data | output | 8 | Byte at the stack pointer |
| sp | output | 8 | Stack pointer |
| sfr_rd_en | output | 1 | Register-space read request |
| sfr_raddr | output | 8 | Register-space read address |
| sfr_rdata | input | 8 | Register-space read data |
| sfr_wr_en | output | 1 | Register-space write request |
| sfr_waddr | output | 8 | Register-space write address |
| sfr_wdata | output | 8 | Register-space write data |

## Verification
The main decode is driven with one access pattern per addressing mode. The patterns use addresses that would alias if decoded wrongly. An indirect write at 90h must not show up through the direct path. A register access with stray upper address bits must land in the selected bank. A bit address with bit 7 set must hit the same window bit as it does with bit 7 clear. Successive bit writes and clears in one byte show whether the merge keeps its neighbours. Same-cycle read/write pairs show whether reads come before writes. Stack sequences cover push-only, pop-only, simultaneous push and pop, a push colliding with a port write, and the pointer wrap below zero.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int unsigned IRAM_ADDR_W   = 8;
  localparam int unsigned IRAM_DATA_W   = 8;
  localparam int unsigned IRAM_BANKS    = 4;
  localparam int unsigned IRAM_BANK_REGS = 8;
  localparam logic [7:0]  IRAM_BIT_BASE = 8'h20;
  localparam logic [7:0]  IRAM_SP_INIT  = 8'h07;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'b00,
    MODE_INDIRECT = 2'b01,
    MODE_BIT      = 2'b10,
    MODE_REG      = 2'b11
  } iram_mode_e;
endpackage

// File: rtl/iram_addr_decode.sv
module iram_addr_decode
  import iram_pkg::*;
#(
  parameter int unsigned ADDR_W   = IRAM_ADDR_W,
  parameter int unsigned DATA_W   = IRAM_DATA_W,
  parameter int unsigned BANKS    = IRAM_BANKS,
  parameter int unsigned REGS     = IRAM_BANK_REGS,
  parameter logic [ADDR_W-1:0] BIT_BASE = IRAM_BIT_BASE,
  localparam int unsigned BANK_W  = $clog2(BANKS),
  localparam int unsigned BPOS_W  = $clog2(DATA_W)
) (
  input  iram_mode_e         mode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BANK_W-1:0]  bank,
  output logic [ADDR_W-1:0]  byte_addr,
  output logic [BPOS_W-1:0]  bit_idx,
  output logic               to_sfr,
  output logic               is_bit
);
  localparam int unsigned REG_W = $clog2(REGS);
  localparam int unsigned BOFS_W = ADDR_W - 1 - BPOS_W;

  logic [BOFS_W-1:0] bit_byte_ofs;
  logic [ADDR_W-1:0] reg_byte;

  assign bit_byte_ofs = addr[ADDR_W-2:BPOS_W];
  assign reg_byte     = ADDR_W'({bank, addr[REG_W-1:0]});

  always_comb begin
    byte_addr = addr;
    bit_idx   = '0;
    to_sfr    = 1'b0;
    is_bit    = 1'b0;
    unique case (mode)
      MODE_DIRECT: begin
        to_sfr = addr[ADDR_W-1];
      end
      MODE_INDIRECT: begin
        byte_addr = addr;
      end
      MODE_BIT: begin
        byte_addr = BIT_BASE + ADDR_W'(bit_byte_ofs);
        bit_idx   = addr[BPOS_W-1:0];
        is_bit    = 1'b1;
      end
      MODE_REG: begin
        byte_addr = reg_byte;
      end
      default: byte_addr = addr;
    endcase
  end
endmodule

// File: rtl/iram_stack_ptr.sv
module iram_stack_ptr
  import iram_pkg::*;
#(
  parameter int unsigned ADDR_W = IRAM_ADDR_W,
  parameter logic [ADDR_W-1:0] SP_INIT = IRAM_SP_INIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] push_addr,
  output logic              push_go
);
  logic pop_go;

  assign push_go   = push & ~pop;
  assign pop_go    = pop & ~push;
  assign push_addr = sp + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= SP_INIT;
    end else if (push_go) begin
      sp <= push_addr;
    end else if (pop_go) begin
      sp <= sp - ADDR_W'(1);
    end
  end
endmodule

// File: rtl/iram_store.sv
module iram_store
  import iram_pkg::*;
#(
  parameter int unsigned ADDR_W = IRAM_ADDR_W,
  parameter int unsigned DATA_W = IRAM_DATA_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned BPOS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] taddr,
  output logic [DATA_W-1:0] tdata,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wbit,
  input  logic [BPOS_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pe,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] merged;

  assign rdata = mem[raddr];
  assign tdata = mem[taddr];

  always_comb begin
    if (wbit) begin
      merged       = mem[waddr];
      merged[widx] = wdata[0];
    end else begin
      merged = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (we) mem[waddr] <= merged;
      if (pe) mem[paddr] <= pdata;
    end
  end
endmodule

// File: rtl/iram_ctrl.sv
module iram_ctrl
  import iram_pkg::*;
#(
  parameter int unsigned ADDR_W = IRAM_ADDR_W,
  parameter int unsigned DATA_W = IRAM_DATA_W,
  parameter int unsigned BANKS  = IRAM_BANKS,
  localparam int unsigned BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              rd_en,
  input  logic [1:0]        rd_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [1:0]        wr_mode,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [ADDR_W-1:0] sp,
  output logic              sfr_rd_en,
  output logic [ADDR_W-1:0] sfr_raddr,
  input  logic [DATA_W-1:0] sfr_rdata,
  output logic              sfr_wr_en,
  output logic [ADDR_W-1:0] sfr_waddr,
  output logic [DATA_W-1:0] sfr_wdata
);
  localparam int unsigned BPOS_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] rd_byte_addr, wr_byte_addr, push_addr;
  logic [BPOS_W-1:0] rd_bit_idx, wr_bit_idx;
  logic              rd_to_sfr, wr_to_sfr, rd_is_bit, wr_is_bit, push_go;
  logic [DATA_W-1:0] ram_rdata;

  iram_addr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANKS)) u_rd_dec (
    .mode(iram_mode_e'(rd_mode)), .addr(rd_addr), .bank(bank_sel),
    .byte_addr(rd_byte_addr), .bit_idx(rd_bit_idx),
    .to_sfr(rd_to_sfr), .is_bit(rd_is_bit)
  );

  iram_addr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANKS)) u_wr_dec (
    .mode(iram_mode_e'(wr_mode)), .addr(wr_addr), .bank(bank_sel),
    .byte_addr(wr_byte_addr), .bit_idx(wr_bit_idx),
    .to_sfr(wr_to_sfr), .is_bit(wr_is_bit)
  );

  iram_stack_ptr #(.ADDR_W(ADDR_W)) u_sp (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .sp(sp), .push_addr(push_addr), .push_go(push_go)
  );

  iram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst),
    .raddr(rd_byte_addr), .rdata(ram_rdata),
    .taddr(sp), .tdata(pop_data),
    .we(wr_en & ~wr_to_sfr), .waddr(wr_byte_addr), .wbit(wr_is_bit),
    .widx(wr_bit_idx), .wdata(wr_data),
    .pe(push_go), .paddr(push_addr), .pdata(push_data)
  );

  assign sfr_rd_en = rd_en & rd_to_sfr;
  assign sfr_raddr = rd_addr;
  assign sfr_wr_en = wr_en & wr_to_sfr;
  assign sfr_waddr = wr_addr;
  assign sfr_wdata = wr_data;

  always_comb begin
    if (!rd_en)         rd_data = '0;
    else if (rd_to_sfr) rd_data = sfr_rdata;
    else if (rd_is_bit) rd_data = DATA_W'(ram_rdata[rd_bit_idx]);
    else                rd_data = ram_rdata;
  end
endmodule

// File: rtl/iram_ctrl_chk.sv
module iram_ctrl_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [1:0]        rd_mode,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_en,
  input logic [1:0]        wr_mode,
  input logic              push,
  input logic [DATA_W-1:0] push_data,
  input logic              pop,
  input logic [DATA_W-1:0] pop_data,
  input logic [ADDR_W-1:0] sp,
  input logic              sfr_rd_en,
  input logic [ADDR_W-1:0] sfr_raddr,
  input logic [DATA_W-1:0] sfr_rdata,
  input logic              sfr_wr_en
);
  // R2
  assert_direct_hi_sfr_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_mode == 2'b00 && rd_addr[ADDR_W-1])
      |-> (sfr_rd_en && sfr_raddr == rd_addr && rd_data == sfr_rdata));

  // R3
  assert_indirect_no_sfr_R3: assert property (@(posedge clk) disable iff (rst)
    ((rd_en && rd_mode == 2'b01) || (wr_en && wr_mode == 2'b01))
      |-> (!sfr_rd_en && !sfr_wr_en));

  // R5
  assert_bit_read_narrow_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_mode == 2'b10) |-> (rd_data[DATA_W-1:1] == '0));

  // R7
  assert_push_top_R7: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (sp == $past(sp) + ADDR_W'(1) && pop_data == $past(push_data)));

  // R8
  assert_pop_dec_R8: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (sp == $past(sp) - ADDR_W'(1)));

  // R9
  assert_push_pop_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> ($stable(sp) && $stable(pop_data)));

  // R12
  assert_idle_read_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rd_data == '0 && !sfr_rd_en));
endmodule

bind iram_ctrl iram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_mode(rd_mode), .rd_addr(rd_addr),
  .rd_data(rd_data), .wr_en(wr_en), .wr_mode(wr_mode), .push(push),
  .push_data(push_data), .pop(pop), .pop_data(pop_data), .sp(sp),
  .sfr_rd_en(sfr_rd_en), .sfr_raddr(sfr_raddr), .sfr_rdata(sfr_rdata),
  .sfr_wr_en(sfr_wr_en)
);

// File: tb/sim_iram_ctrl.sv
`timescale 1ns/100ps
module sim_iram_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] bank_sel;
  logic       rd_en, wr_en, push, pop, sfr_rd_en, sfr_wr_en;
  logic [1:0] rd_mode, wr_mode;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data, push_data, pop_data, sp;
  logic [7:0] sfr_raddr, sfr_rdata, sfr_waddr, sfr_wdata;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  iram_ctrl u0 (
    .clk(clk), .rst(rst), .bank_sel(bank_sel),
    .rd_en(rd_en), .rd_mode(rd_mode), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data),
    .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data), .sp(sp),
    .sfr_rd_en(sfr_rd_en), .sfr_raddr(sfr_raddr), .sfr_rdata(sfr_rdata),
    .sfr_wr_en(sfr_wr_en), .sfr_waddr(sfr_waddr), .sfr_wdata(sfr_wdata)
  );

  // {wen, wmode, waddr, wdata, ren, rmode, raddr, bank, expected rd_data}
  localparam int NV = 16;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1,2'd0,8'h10,8'hA5, 1'b1,2'd0,8'h10, 2'd0, 8'h00}, // R10 old value
    {1'b1,2'd1,8'h90,8'h3C, 1'b1,2'd0,8'h10, 2'd0, 8'hA5}, // R2 direct low
    {1'b1,2'd3,8'h03,8'h77, 1'b1,2'd1,8'h90, 2'd2, 8'h3C}, // R3 upper half
    {1'b0,2'd0,8'h00,8'h00, 1'b1,2'd0,8'h13, 2'd2, 8'h77}, // R4 bank 2
    {1'b1,2'd3,8'h0F,8'hE1, 1'b1,2'd3,8'h05, 2'd3, 8'h00}, // R4 stray bits
    {1'b0,2'd0,8'h00,8'h00, 1'b1,2'd1,8'h1F, 2'd0, 8'hE1}, // R4 landed at 1Fh
    {1'b1,2'd2,8'h0B,8'h01, 1'b1,2'd0,8'h21, 2'd0, 8'h00}, // R5 set bit 3
    {1'b1,2'd2,8'h8C,8'h01, 1'b1,2'd0,8'h21, 2'd0, 8'h08}, // R5 addr[7] ignored
    {1'b0,2'd0,8'h00,8'h00, 1'b1,2'd0,8'h21, 2'd0, 8'h18}, // R6 both bits
    {1'b1,2'd2,8'h0B,8'hFE, 1'b1,2'd2,8'h0C, 2'd0, 8'h01}, // R6 clear bit 3
    {1'b0,2'd0,8'h00,8'h00, 1'b1,2'd0,8'h21, 2'd0, 8'h10}, // R6 neighbour kept
    {1'b1,2'd0,8'h21,8'hFF, 1'b1,2'd2,8'h8B, 2'd0, 8'h00}, // R10 bit read old
    {1'b1,2'd1,8'h2F,8'h80, 1'b1,2'd2,8'h0B, 2'd0, 8'h01}, // R5 bit read
    {1'b0,2'd0,8'h00,8'h00, 1'b1,2'd2,8'h7F, 2'd0, 8'h01}, // R5 last bit
    {1'b1,2'd3,8'h07,8'hC3, 1'b1,2'd3,8'h07, 2'd1, 8'h00}, // R10 register
    {1'b0,2'd0,8'h00,8'h00, 1'b1,2'd1,8'h0F, 2'd0, 8'hC3}  // R4 bank 1
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rd_en = 0; rd_mode = 0; rd_addr = 0; wr_en = 0; wr_mode = 0; wr_addr = 0;
    wr_data = 0; push = 0; push_data = 0; pop = 0; sfr_rdata = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_reset();
    idle(); bank_sel = 0; rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
  endtask

  task automatic rd_ind(input logic [7:0] a, input string tag, input logic [7:0] exp);
    rd_en = 1; rd_mode = 2'd1; rd_addr = a; #1;
    chk(tag, rd_data, exp);
    rd_en = 0;
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R1 sp after reset", sp, 8'h07);
    chk("R1 top byte after reset", pop_data, 8'h00);
    rd_ind(8'hC5, "R1 byte C5 after reset", 8'h00);

    for (int v = 0; v < NV; v++) begin
      {wr_en, wr_mode, wr_addr, wr_data, rd_en, rd_mode, rd_addr, bank_sel} = VEC[v][39:8];
      #1;
      chk($sformatf("R2/R3/R4/R5/R6/R10 vector %0d", v), rd_data, VEC[v][7:0]);
      tick();
    end
    bank_sel = 0;

    // R12
    rd_en = 0; rd_mode = 0; rd_addr = 8'h10; sfr_rdata = 8'h5E; #1;
    chk("R12 idle rd_data", rd_data, 8'h00);
    chk("R12 idle sfr_rd_en", {7'd0, sfr_rd_en}, 8'h00);
    tick();

    // R2 register-space routing
    wr_en = 1; wr_mode = 0; wr_addr = 8'h85; wr_data = 8'h5A; #1;
    chk("R2 sfr_wr_en", {7'd0, sfr_wr_en}, 8'h01);
    chk("R2 sfr_waddr", sfr_waddr, 8'h85);
    chk("R2 sfr_wdata", sfr_wdata, 8'h5A);
    tick();
    rd_ind(8'h85, "R2 RAM untouched at 85h", 8'h00);
    rd_en = 1; rd_mode = 0; rd_addr = 8'hC0; sfr_rdata = 8'h9E; #1;
    chk("R2 rd_data from sfr", rd_data, 8'h9E);
    chk("R2 sfr_raddr", sfr_raddr, 8'hC0);
    rd_mode = 1; #1;
    chk("R3 indirect C0h no sfr", {7'd0, sfr_rd_en}, 8'h00);
    tick();

    // R7 push
    push = 1; push_data = 8'h11; tick(); #1;
    chk("R7 sp after first push", sp, 8'h08);
    chk("R7 top after push", pop_data, 8'h11);
    rd_ind(8'h08, "R7 first push at 08h", 8'h11);
    push = 1; push_data = 8'h22; tick(); #1;
    chk("R7 sp second push", sp, 8'h09);

    // R9
    push = 1; pop = 1; push_data = 8'h99; tick(); #1;
    chk("R9 sp held", sp, 8'h09);
    chk("R9 top held", pop_data, 8'h22);
    rd_ind(8'h0A, "R9 no write above sp", 8'h00);

    // R8 pop
    pop = 1; #1;
    chk("R8 pop shows top", pop_data, 8'h22);
    tick(); #1;
    chk("R8 sp after pop", sp, 8'h08);
    chk("R8 next top", pop_data, 8'h11);
    pop = 1; tick(); #1;
    chk("R8 sp back to 07", sp, 8'h07);

    // R11 push and port write collide at 08h
    push = 1; push_data = 8'h44; wr_en = 1; wr_mode = 0; wr_addr = 8'h08; wr_data = 8'h55;
    tick(); #1;
    rd_ind(8'h08, "R11 push wins", 8'h44);
    chk("R11 sp", sp, 8'h08);

    // R8 wrap
    do_reset();
    for (int k = 0; k < 8; k++) begin
      pop = 1; tick();
    end
    #1;
    chk("R8 sp wraps to FF", sp, 8'hFF);
    push = 1; push_data = 8'h6B; tick(); #1;
    chk("R7 sp wraps to 00", sp, 8'h00);
    rd_ind(8'h00, "R7 push after wrap at 00h", 8'h6B);
    rd_ind(8'h10, "R1 reset cleared 10h", 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule